// File: doc/BRIEF.md
# Sliding Window Memory Feeder

This block walks a stored array of pixel intensity words held in one single-port on-chip memory. It moves the words, in address order, through a shift-register window that is as wide as the number of processing elements plus two. When a batch of fetches is complete, it hands the whole window to a pair of external compute units that run side by side. It then writes their two answers back into the same memory at consecutive addresses. The read and write address counters, the sequencing of the one memory port, the window register and the start/done handshake with the compute units all live here. The arithmetic the compute units perform does not.

A run begins with a start pulse. Two priming fetches come first. After that, each pass fetches two more words, starts the compute units and waits for their done pulse, then stores both results. The loop ends once the last array word has been read. If the remaining word count is odd, the last pass fetches a single word and still stores two results. Write addresses always trail read addresses, so the results can safely overwrite words that have already been consumed.

Top module: `window_feeder`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd_en`, `mem_wr_en` and `cu_start` are all low.
- R2: A start pulse while idle raises `busy` on the next cycle and immediately issues a read at address 0.
- R3: Across a run, every address from 0 to ARRAY_LEN-1 is read exactly once, in ascending order, one read at a time. The memory returns data on the cycle after the address.
- R4: Window cell j occupies bits [j*WORD_W +: WORD_W] of `cu_window`. Each fetched word enters the highest cell (NUM_PE+1) while every other cell takes the value of the cell above it. All cells clear to zero when a run starts.
- R5: Two fetches prime the window. Every pass after that performs two fetches before `cu_start`. The final pass performs one fetch when only one unread word remains.
- R6: `cu_start` is a one-cycle pulse, and `cu_window` holds steady from that pulse until `cu_done` is accepted.
- R7: After `cu_done`, `cu_res_a` is written at the current write address and `cu_res_b` at the next address, in two consecutive cycles. The write address begins at 0 on each run.
- R8: `mem_rd_en` and `mem_wr_en` are never high in the same cycle.
- R9: After the final pair of writes, `done` is high for exactly one cycle, in the same cycle that `busy` returns low.
- R10: A start pulse that arrives while `busy` is high has no effect on the read sequence, the window or the results.
- R11: A second run after `done` again reads from address 0 and writes from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a run when idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| mem_addr | output | AW | Shared memory address (read or write) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid the cycle after the read strobe |
| cu_start | output | 1 | Starts both compute units |
| cu_window | output | (NUM_PE+2)*WORD_W | Window contents, cell 0 in the low bits |
| cu_done | input | 1 | Both compute units have finished |
| cu_res_a | input | WORD_W | First compute unit result |
| cu_res_b | input | WORD_W | Second compute unit result |

## Verification
The assertions assume that `cu_done` arrives only while the block is waiting on a `cu_start` it has issued, at most once per pulse, and that the memory returns read data exactly one cycle after the strobe. The bench models the memory and the compute units under this contract: it raises `cu_done` once per `cu_start`, after a latency taken from its table that includes zero. It also drives stray start pulses only while a run is in flight, so the rule that such starts are ignored can be observed at the memory port.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD   = 3'd1,
    S_CAP  = 3'd2,
    S_WAIT = 3'd3,
    S_WRA  = 3'd4,
    S_WRB  = 3'd5
  } wf_state_t;
endpackage

// File: rtl/wf_addr_ctr.sv
module wf_addr_ctr #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wf_window.sv
module wf_window #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      shift,
  input  logic [WORD_W-1:0]         din,
  output logic [DEPTH*WORD_W-1:0]   cells
);
  logic [WORD_W-1:0] cell_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_cell
    logic [WORD_W-1:0] feed;
    if (k == DEPTH - 1) begin : g_tail
      assign feed = din;
    end else begin : g_body
      assign feed = cell_q[k+1];
    end

    always_ff @(posedge clk) begin
      if (rst || clr) cell_q[k] <= '0;
      else if (shift) cell_q[k] <= feed;
    end

    assign cells[k*WORD_W +: WORD_W] = cell_q[k];
  end
endmodule

// File: rtl/wf_seq.sv
module wf_seq
  import wf_pkg::*;
#(
  parameter int ARRAY_LEN = 1000,
  parameter int CW        = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cu_done,
  input  logic [CW-1:0] rd_cnt,
  output logic          run_clr,
  output logic          rd_en,
  output logic          win_shift,
  output logic          wr_en,
  output logic          sel_b,
  output logic          wait_cu,
  output logic          busy,
  output logic          done,
  output logic          cu_start
);
  wf_state_t  state;
  logic [1:0] fetch_left;
  logic       primed;
  logic [1:0] next_fetch;
  logic       all_read;

  assign all_read   = (rd_cnt == CW'(ARRAY_LEN));
  assign next_fetch = (rd_cnt <= CW'(ARRAY_LEN - 2)) ? 2'd2 : 2'd1;

  assign run_clr   = (state == S_IDLE) && start;
  assign rd_en     = (state == S_RD);
  assign win_shift = (state == S_CAP);
  assign wr_en     = (state == S_WRA) || (state == S_WRB);
  assign sel_b     = (state == S_WRB);
  assign wait_cu   = (state == S_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      fetch_left <= '0;
      primed     <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      cu_start   <= 1'b0;
    end else begin
      done     <= 1'b0;
      cu_start <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            busy       <= 1'b1;
            fetch_left <= 2'd2;
            primed     <= 1'b0;
            state      <= S_RD;
          end
        end
        S_RD: begin
          fetch_left <= fetch_left - 2'd1;
          state      <= S_CAP;
        end
        S_CAP: begin
          if (fetch_left != 2'd0) begin
            state <= S_RD;
          end else if (!primed) begin
            primed     <= 1'b1;
            fetch_left <= next_fetch;
            state      <= S_RD;
          end else begin
            cu_start <= 1'b1;
            state    <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (cu_done) state <= S_WRA;
        end
        S_WRA: state <= S_WRB;
        S_WRB: begin
          if (all_read) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            fetch_left <= next_fetch;
            state      <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: compute start is a single-cycle pulse
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (rst)
    cu_start |=> !cu_start);
  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: busy only drops together with done
  a_r9_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R5: compute units only start after the whole array prefix is primed
  a_r5_primed_before_cu: assert property (@(posedge clk) disable iff (rst)
    $rose(cu_start) |-> (primed && rd_cnt >= CW'(3)));
endmodule

// File: rtl/window_feeder.sv
module window_feeder #(
  parameter int WORD_W    = 16,
  parameter int NUM_PE    = 4,
  parameter int ARRAY_LEN = 1000,
  localparam int WIN      = NUM_PE + 2,
  localparam int AW       = (ARRAY_LEN > 1) ? $clog2(ARRAY_LEN) : 1,
  localparam int CW       = $clog2(ARRAY_LEN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic [AW-1:0]           mem_addr,
  output logic                    mem_rd_en,
  output logic                    mem_wr_en,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    cu_start,
  output logic [WIN*WORD_W-1:0]   cu_window,
  input  logic                    cu_done,
  input  logic [WORD_W-1:0]       cu_res_a,
  input  logic [WORD_W-1:0]       cu_res_b
);
  logic [CW-1:0]     rd_cnt;
  logic [CW-1:0]     wr_cnt;
  logic              run_clr;
  logic              win_shift;
  logic              sel_b;
  logic              wait_cu;
  logic [WORD_W-1:0] res_a_q;
  logic [WORD_W-1:0] res_b_q;

  wf_seq #(.ARRAY_LEN(ARRAY_LEN), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cu_done(cu_done), .rd_cnt(rd_cnt),
    .run_clr(run_clr), .rd_en(mem_rd_en), .win_shift(win_shift),
    .wr_en(mem_wr_en), .sel_b(sel_b), .wait_cu(wait_cu),
    .busy(busy), .done(done), .cu_start(cu_start)
  );

  wf_addr_ctr #(.CW(CW)) u_rd_ctr (
    .clk(clk), .rst(rst), .clr(run_clr), .inc(mem_rd_en), .cnt(rd_cnt)
  );

  wf_addr_ctr #(.CW(CW)) u_wr_ctr (
    .clk(clk), .rst(rst), .clr(run_clr), .inc(mem_wr_en), .cnt(wr_cnt)
  );

  wf_window #(.WORD_W(WORD_W), .DEPTH(WIN)) u_win (
    .clk(clk), .rst(rst), .clr(run_clr), .shift(win_shift),
    .din(mem_rdata), .cells(cu_window)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_a_q <= '0;
      res_b_q <= '0;
    end else if (wait_cu && cu_done) begin
      res_a_q <= cu_res_a;
      res_b_q <= cu_res_b;
    end
  end

  assign mem_addr  = mem_wr_en ? wr_cnt[AW-1:0] : rd_cnt[AW-1:0];
  assign mem_wdata = sel_b ? res_b_q : res_a_q;

  // R3: reads never run past the array
  a_r3_rd_in_range: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (rd_cnt < CW'(ARRAY_LEN)));
  // R7: writes stay inside the array and trail the reads
  a_r7_wr_trails_rd: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (wr_cnt < rd_cnt));
  // R7: the second store of a pair goes to the next address
  a_r7_wr_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_en) |=> (mem_wr_en && mem_addr == $past(mem_addr) + 1'b1));
  // R6: window frozen while the compute units work
  a_r6_window_hold: assert property (@(posedge clk) disable iff (rst)
    (wait_cu && $past(wait_cu)) |-> $stable(cu_window));
endmodule

// File: tb/window_feeder_bench.sv
module window_feeder_bench;
  localparam int W    = 16;
  localparam int N    = 4;
  localparam int WIN  = N + 2;
  localparam int LEN  = 11;
  localparam int AW   = 4;
  localparam int NIT  = 5;
  // per pass: last array index fetched, compute latency in cycles
  localparam int VEC [NIT][2] = '{'{3, 0}, '{5, 2}, '{7, 1}, '{9, 4}, '{10, 3}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, mem_rd_en, mem_wr_en, cu_start;
  logic cu_done = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [W-1:0] mem_wdata, mem_rdata;
  logic [W-1:0] cu_res_a = '0, cu_res_b = '0;
  logic [WIN*W-1:0] cu_window;

  int checks = 0, fails = 0;
  int rd_seen = 0, wr_seen = 0, rd_err = 0, wr_err = 0, collide = 0;
  logic mon_en = 1'b0;
  logic [W-1:0] mem [LEN];
  logic [W-1:0] exp_mem [LEN];

  always #10 clk = ~clk;

  window_feeder #(.WORD_W(W), .NUM_PE(N), .ARRAY_LEN(LEN)) u_window_feeder (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cu_start(cu_start),
    .cu_window(cu_window), .cu_done(cu_done), .cu_res_a(cu_res_a), .cu_res_b(cu_res_b)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (mem_rd_en && mem_wr_en) collide++;
      if (mem_rd_en) begin
        if (int'(mem_addr) != rd_seen) rd_err++;
        rd_seen++;
      end
      if (mem_wr_en) begin
        if (int'(mem_addr) != wr_seen) wr_err++;
        wr_seen++;
      end
    end
  end

  function automatic logic [W-1:0] word(int run, int i);
    return (run == 0) ? W'(16'h0100 + i * 37) : W'(16'h8000 ^ (i * 11 + 5));
  endfunction

  function automatic logic [WIN*W-1:0] exp_win(int run, int last);
    logic [WIN*W-1:0] v = '0;
    for (int j = 0; j < WIN; j++) begin
      int idx = last - (WIN - 1) + j;
      if (idx >= 0) v[j*W +: W] = word(run, idx);
    end
    return v;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_pass(int run);
    for (int i = 0; i < LEN; i++) begin
      mem[i] = word(run, i);
      exp_mem[i] = word(run, i);
    end
    rd_seen = 0; wr_seen = 0; rd_err = 0; wr_err = 0; collide = 0;
    mon_en = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 busy after start", busy, 1);
    chk("R2/R11 first read at 0", {mem_rd_en, 4'(mem_addr)}, {1'b1, 4'd0});
    for (int k = 0; k < NIT; k++) begin
      logic [WIN*W-1:0] ew;
      ew = exp_win(run, VEC[k][0]);
      while (!cu_start) @(negedge clk);
      chk("R4 window contents", cu_window, ew);
      chk("R5 fetches before compute", rd_seen, VEC[k][0] + 1);
      exp_mem[2*k]   = ew[0*W +: W] + ew[5*W +: W];
      exp_mem[2*k+1] = ew[5*W +: W] ^ 16'hA5A5;
      if (run == 0 && k == 1) start = 1'b1;  // R10 stray start
      for (int d = 0; d < VEC[k][1]; d++) begin
        @(negedge clk);
        start = 1'b0;
        if (d == 0) chk("R6 start pulse width", cu_start, 0);
      end
      chk("R6 window held", cu_window, ew);
      cu_res_a = exp_mem[2*k];
      cu_res_b = exp_mem[2*k+1];
      cu_done = 1'b1;
      @(negedge clk);
      cu_done = 1'b0;
      start = 1'b0;
      chk("R10 busy kept", busy, 1);
    end
    for (int t = 0; t < 40 && !done; t++) @(negedge clk);
    chk("R9 done with busy low", {done, busy}, 2'b10);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    mon_en = 1'b0;
    chk("R3 read order", rd_err, 0);
    chk("R3 read count", rd_seen, LEN);
    chk("R7/R11 write order", wr_err, 0);
    chk("R7 write count", wr_seen, 2 * NIT);
    chk("R8 no shared cycle", collide, 0);
    for (int i = 0; i < LEN; i++) chk("R7/R10 memory word", mem[i], exp_mem[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle outputs", {busy, done, mem_rd_en, mem_wr_en, cu_start}, 5'b0);
    chk("R4 window cleared", cu_window, '0);
    run_pass(0);
    repeat (3) @(negedge clk);
    run_pass(1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule